// File: doc/BRIEF.md
# Warm Reset Release Sequencer

This block turns an active-low external warm-reset pin into an ordered release of the resets inside a chip. A low level on the pin pulls the MAIN-domain reset down at once, through gates only. The stateful part of the sequencer acts only when the synchronized pin has stayed low for a minimum width. That width is set in nanoseconds and converted to reference-clock cycles: 1.2 µs at a 12.5 MHz reference gives 15 cycles. A shorter low pulse is treated as a glitch and does not disturb the sequence.

Release begins once the pin is high, the supplies report good and the oscillator reports a stable clock. The MAIN reset and the module global reset come out of reset first. One cycle later the system controller leaves reset, and the reset-status output deasserts with it. The application core is released, with its clock enabled, once the system controller reports that clock and boot setup is done. When the core asks for code authentication, the sequencer gates the core clock for a set number of cycles, then holds the core in reset, re-enables the clock one cycle before the end, and lets the core run again.

All inputs except the pin's direct path to the MAIN reset pass through two-flop synchronizers. A loss of supplies-good, or a new qualified reset pulse, sends the machine back to its full-reset state from any stage. Oscillators, PLLs, power monitors, I/O configuration, fuses, the timebase, boot-mode latches and debug logic are not driven by this block.

Top module: `warm_reset_seq`

## Requirements
- R1: `main_rst_n` is low in any cycle in which `rst_pin_n` is low, with no clock edge needed between the two.
- R2: A low pulse on `rst_pin_n` that lasts fewer than MIN_LOW_CYC clock cycles (15 by default) leaves every sequenced output unchanged.
- R3: A low pulse of at least MIN_LOW_CYC cycles puts the block into full reset until the pin returns high. In full reset `main_rst_n`, `mod_grst_n`, `sysctl_rst_n`, `rst_stat_n` and `core_rst_n` are all 0 and `core_clk_en` is 0.
- R4: Release starts only when the pin is high, `supplies_ok` is 1 and `osc_stable` is 1. Its first step sets `mod_grst_n` (and the sequencer's hold on `main_rst_n`) to 1.
- R5: `sysctl_rst_n` and `rst_stat_n` go to 1 together, exactly one cycle after `mod_grst_n` goes to 1.
- R6: `core_rst_n` and `core_clk_en` stay 0 until `sysctl_done` has been seen at 1. They then go to 1 together.
- R7: A one-cycle `auth_req` pulse while the core runs drops `core_clk_en` to 0 for exactly GATE_CYC cycles (8 by default), with `core_rst_n` held at 1.
- R8: After the gated window, `core_rst_n` is 0 for exactly HOLD_CYC cycles (16 by default). `core_clk_en` is 1 only in the last of those cycles, and both outputs are 1 afterwards.
- R9: Whenever `supplies_ok` is 0, the block returns to full reset (the R3 output values) within a few cycles, from any stage.
- R10: While `rst` is 1, the block is in full reset with the R3 output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | External warm-reset pin, active low |
| supplies_ok | input | 1 | All supplies at their proper level |
| osc_stable | input | 1 | Oscillator clock is stable |
| sysctl_done | input | 1 | System controller has finished clock and boot setup |
| auth_req | input | 1 | Core requests authentication of loaded code (pulse) |
| main_rst_n | output | 1 | MAIN-domain reset, active low |
| mod_grst_n | output | 1 | Module global reset, active low |
| sysctl_rst_n | output | 1 | System-controller reset, active low |
| rst_stat_n | output | 1 | Reset-status output, low while the reset is in progress |
| core_rst_n | output | 1 | Application-core reset, active low |
| core_clk_en | output | 1 | Application-core clock enable |

## Verification
On every cycle the assertions check the release order: the module reset leads the system controller by a cycle, the core is never out of reset while the system controller is in reset, the core clock is off before the core reset falls and back on before it rises, and a qualified pulse or a supply loss leads to full reset. The direct combinational path from the pin to the MAIN reset is also checked on every cycle. Only the bench scenarios can show the exact widths. These are the 14-cycle versus 15-cycle pulse boundary, the 8-cycle gate window and 16-cycle hold window, and the wait on the oscillator flag. Random pulse lengths are compared against the glitch threshold.

// File: rtl/wrst_pkg.sv
`timescale 1ns/1ps
package wrst_pkg;

    typedef enum logic [2:0] {
        ST_FULL   = 3'd0,
        ST_MODREL = 3'd1,
        ST_SYSREL = 3'd2,
        ST_RUN    = 3'd3,
        ST_GATE   = 3'd4,
        ST_HOLD   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic main_hold_n;
        logic mod_n;
        logic sys_n;
        logic stat_n;
        logic core_n;
        logic clk_en;
    } rst_out_t;

    // Bit order of the synchronized status bus
    localparam int unsigned SI_PIN  = 0;
    localparam int unsigned SI_SUP  = 1;
    localparam int unsigned SI_OSC  = 2;
    localparam int unsigned SI_DONE = 3;
    localparam int unsigned SI_AUTH = 4;
    localparam int unsigned SI_NUM  = 5;

    // Round a time in ns up to whole reference-clock cycles
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned ref_khz);
        return (ns * ref_khz + 999999) / 1000000;
    endfunction

    function automatic rst_out_t decode_outputs(input seq_state_e st, input logic hold_last);
        rst_out_t o;
        o = '0;
        case (st)
            ST_FULL:   o = '0;
            ST_MODREL: begin o.main_hold_n = 1'b1; o.mod_n = 1'b1; end
            ST_SYSREL: begin o.main_hold_n = 1'b1; o.mod_n = 1'b1; o.sys_n = 1'b1; o.stat_n = 1'b1; end
            ST_RUN:    o = '1;
            ST_GATE:   begin o = '1; o.clk_en = 1'b0; end
            ST_HOLD:   begin o = '1; o.core_n = 1'b0; o.clk_en = hold_last; end
            default:   o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/wrst_sync.sv
`timescale 1ns/1ps
module wrst_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wrst_width_filter.sv
`timescale 1ns/1ps
module wrst_width_filter #(
    parameter int unsigned MIN_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic qual
);
    localparam int unsigned LOW_W = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
    localparam logic [LOW_W-1:0] SAT = LOW_W'(MIN_CYC - 1);

    // Number of earlier consecutive low cycles, saturating at MIN_CYC-1
    logic [LOW_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || pin_s)        low_cnt <= '0;
        else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
    end

    assign qual = !pin_s && (low_cnt == SAT);

    AST_QUAL_NEEDS_LOW_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(qual) && (MIN_CYC > 1) |-> !$past(pin_s)) else $error("qual without low run"); // R2
endmodule

// File: rtl/wrst_fsm.sv
`timescale 1ns/1ps
module wrst_fsm
    import wrst_pkg::*;
#(
    parameter int unsigned GATE_CYC = 8,
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     qual,
    input  logic     pin_s,
    input  logic     sup_s,
    input  logic     osc_s,
    input  logic     done_s,
    input  logic     auth_s,
    output rst_out_t outs
);
    localparam int unsigned MAXC  = (GATE_CYC > HOLD_CYC) ? GATE_CYC : HOLD_CYC;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] GATE_LAST = CNT_W'(GATE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !sup_s || qual) begin
            state <= ST_FULL;
            cnt   <= '0;
        end else begin
            case (state)
                ST_FULL:   if (pin_s && osc_s) state <= ST_MODREL;
                ST_MODREL: state <= ST_SYSREL;
                ST_SYSREL: if (done_s) state <= ST_RUN;
                ST_RUN:    if (auth_s) begin state <= ST_GATE; cnt <= '0; end
                ST_GATE:   if (cnt == GATE_LAST) begin state <= ST_HOLD; cnt <= '0; end
                           else cnt <= cnt + 1'b1;
                ST_HOLD:   if (cnt == HOLD_LAST) begin state <= ST_RUN; cnt <= '0; end
                           else cnt <= cnt + 1'b1;
                default:   state <= ST_FULL;
            endcase
        end
    end

    assign outs = decode_outputs(state, (state == ST_HOLD) && (cnt == HOLD_LAST));

    AST_MOD_LEADS_SYS: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.sys_n) |-> $past(outs.mod_n)) else $error("order"); // R5
    AST_STAT_WITH_SYS: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.sys_n) |-> $rose(outs.stat_n)) else $error("status"); // R5
    AST_CORE_AFTER_SYS: assert property (@(posedge clk) disable iff (rst)
        outs.core_n |-> outs.sys_n && outs.mod_n) else $error("core early"); // R6
    AST_GATE_BEFORE_RST: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.core_n) && outs.sys_n |-> !$past(outs.clk_en)) else $error("gate"); // R7
    AST_CLK_BEFORE_REL: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.core_n) && $past(state == ST_HOLD) |-> $past(outs.clk_en)) else $error("clk"); // R8
    AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (rst)
        !sup_s |=> state == ST_FULL) else $error("supply"); // R9
    AST_QUAL_FULL: assert property (@(posedge clk) disable iff (rst)
        qual |=> state == ST_FULL) else $error("qual"); // R3
endmodule

// File: rtl/warm_reset_seq.sv
`timescale 1ns/1ps
module warm_reset_seq
    import wrst_pkg::*;
#(
    parameter int unsigned REF_KHZ     = 12500,
    parameter int unsigned MIN_LOW_NS  = 1200,
    parameter int unsigned GATE_CYC    = 8,
    parameter int unsigned HOLD_CYC    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin_n,
    input  logic supplies_ok,
    input  logic osc_stable,
    input  logic sysctl_done,
    input  logic auth_req,
    output logic main_rst_n,
    output logic mod_grst_n,
    output logic sysctl_rst_n,
    output logic rst_stat_n,
    output logic core_rst_n,
    output logic core_clk_en
);
    localparam int unsigned MIN_LOW_CYC = ns_to_cycles(MIN_LOW_NS, REF_KHZ);

    logic [SI_NUM-1:0] raw, syn;
    logic              qual;
    rst_out_t          outs;

    always_comb begin
        raw          = '0;
        raw[SI_PIN]  = rst_pin_n;
        raw[SI_SUP]  = supplies_ok;
        raw[SI_OSC]  = osc_stable;
        raw[SI_DONE] = sysctl_done;
        raw[SI_AUTH] = auth_req;
    end

    wrst_sync #(.WIDTH(SI_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    wrst_width_filter #(.MIN_CYC(MIN_LOW_CYC)) u_filt (
        .clk(clk), .rst(rst), .pin_s(syn[SI_PIN]), .qual(qual)
    );

    wrst_fsm #(.GATE_CYC(GATE_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .rst(rst), .qual(qual), .pin_s(syn[SI_PIN]),
        .sup_s(syn[SI_SUP]), .osc_s(syn[SI_OSC]), .done_s(syn[SI_DONE]),
        .auth_s(syn[SI_AUTH]), .outs(outs)
    );

    // Pin reaches the MAIN domain through gates only
    assign main_rst_n   = rst_pin_n & outs.main_hold_n;
    assign mod_grst_n   = outs.mod_n;
    assign sysctl_rst_n = outs.sys_n;
    assign rst_stat_n   = outs.stat_n;
    assign core_rst_n   = outs.core_n;
    assign core_clk_en  = outs.clk_en;

    always_comb begin
        AST_MAIN_FOLLOWS_PIN: assert (rst_pin_n || !main_rst_n) else $error("main"); // R1
    end
endmodule

// File: tb/sim_warm_reset_seq.sv
`timescale 1ns/1ps
module sim_warm_reset_seq;
    localparam int MIN_LOW = 15;
    localparam int GATE    = 8;
    localparam int HOLD    = 16;

    logic clk = 1'b0;
    logic rst, rst_pin_n, supplies_ok, osc_stable, sysctl_done, auth_req;
    logic main_rst_n, mod_grst_n, sysctl_rst_n, rst_stat_n, core_rst_n, core_clk_en;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0;
    bit saw_full = 0, arm = 0;
    int t_mod = -1, t_sys = -1;
    logic prev_mod = 1'b0, prev_sys = 1'b0;

    always #4 clk = ~clk;

    warm_reset_seq u0 (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .supplies_ok(supplies_ok),
        .osc_stable(osc_stable), .sysctl_done(sysctl_done), .auth_req(auth_req),
        .main_rst_n(main_rst_n), .mod_grst_n(mod_grst_n), .sysctl_rst_n(sysctl_rst_n),
        .rst_stat_n(rst_stat_n), .core_rst_n(core_rst_n), .core_clk_en(core_clk_en)
    );

    always @(negedge clk) begin
        cyc++;
        if (arm && !mod_grst_n) saw_full = 1;
        if (mod_grst_n && !prev_mod) t_mod = cyc;
        if (sysctl_rst_n && !prev_sys) t_sys = cyc;
        prev_mod = mod_grst_n;
        prev_sys = sysctl_rst_n;
    end

    function automatic bit expect_valid(input int len);
        return len >= MIN_LOW;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_full(input string req);
        int v;
        v = {main_rst_n, mod_grst_n, sysctl_rst_n, rst_stat_n, core_rst_n, core_clk_en};
        check(v == 0, req, v, 0);
    endtask

    task automatic pulse_pin(input int len);
        rst_pin_n = 1'b0;
        tick(len);
        rst_pin_n = 1'b1;
    endtask

    task automatic auth_cycle(input string tag);
        int gate_c = 0, hold_c = 0, en_in_hold = 0;
        auth_req = 1'b1;
        tick(1);
        auth_req = 1'b0;
        for (int i = 0; i < 45; i++) begin
            if (core_rst_n && !core_clk_en) gate_c++;
            if (!core_rst_n) hold_c++;
            if (!core_rst_n && core_clk_en) en_in_hold++;
            tick(1);
        end
        check(gate_c == GATE, {tag, " R7 gate window"}, gate_c, GATE);
        check(hold_c == HOLD, {tag, " R8 hold window"}, hold_c, HOLD);
        check(en_in_hold == 1, {tag, " R8 clock before release"}, en_in_hold, 1);
        check(core_rst_n && core_clk_en, {tag, " R8 core running after"}, {core_rst_n, core_clk_en}, 3);
    endtask

    initial begin
        rst = 1'b1; rst_pin_n = 1'b1; supplies_ok = 1'b1; osc_stable = 1'b1;
        sysctl_done = 1'b0; auth_req = 1'b0;
        void'($urandom(32'd4242));
        tick(3);
        check_full("R10 reset state");
        rst = 1'b0;
        tick(12);
        check(mod_grst_n && main_rst_n, "R4 first release step", mod_grst_n, 1);
        check(t_sys - t_mod == 1, "R5 sysctl one cycle after module", t_sys - t_mod, 1);
        check(rst_stat_n == sysctl_rst_n && rst_stat_n, "R5 status with sysctl", rst_stat_n, 1);
        tick(20);
        check(!core_rst_n && !core_clk_en, "R6 core held without done", core_rst_n, 0);
        sysctl_done = 1'b1;
        tick(6);
        check(core_rst_n && core_clk_en, "R6 core released after done", {core_rst_n, core_clk_en}, 3);

        // R1 combinational path, on a glitch
        arm = 1; saw_full = 0;
        rst_pin_n = 1'b0;
        #1;
        check(!main_rst_n, "R1 main follows pin at once", main_rst_n, 0);
        tick(MIN_LOW - 1);
        rst_pin_n = 1'b1;
        tick(10);
        check(!saw_full, "R2 14-cycle glitch ignored", saw_full, 0);
        check(core_rst_n && core_clk_en, "R2 core untouched", {core_rst_n, core_clk_en}, 3);

        // R3 exact threshold
        saw_full = 0;
        pulse_pin(MIN_LOW);
        tick(12);
        check(saw_full, "R3 15-cycle pulse resets", saw_full, 1);
        check(core_rst_n, "R3 re-released after pulse", core_rst_n, 1);

        // R3 outputs held in full reset during long pulse
        rst_pin_n = 1'b0;
        tick(25);
        check_full("R3 full reset during long pulse");
        rst_pin_n = 1'b1;
        tick(12);

        // R4 oscillator gating
        osc_stable = 1'b0;
        pulse_pin(20);
        tick(20);
        check(!mod_grst_n, "R4 waits for oscillator", mod_grst_n, 0);
        osc_stable = 1'b1;
        tick(8);
        check(mod_grst_n, "R4 releases once oscillator stable", mod_grst_n, 1);
        tick(6);

        // R7 / R8 authentication, twice
        auth_cycle("first");
        auth_cycle("second");

        // R9 supply loss
        supplies_ok = 1'b0;
        tick(4);
        check_full("R9 supply loss full reset");
        tick(10);
        check(!mod_grst_n, "R9 held while supplies bad", mod_grst_n, 0);
        supplies_ok = 1'b1;
        tick(12);
        check(core_rst_n, "R9 recovery", core_rst_n, 1);

        // Random pulse widths against the threshold
        for (int k = 0; k < 16; k++) begin
            int len;
            len = 1 + int'($urandom % 30);
            saw_full = 0;
            pulse_pin(len);
            tick(14);
            check(saw_full == expect_valid(len), $sformatf("R2/R3 random pulse len=%0d R3", len),
                  saw_full, expect_valid(len));
            check(core_rst_n, "R6 running after random pulse", core_rst_n, 1);
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule